// File: doc/BRIEF.md
# Triggered Multi-Channel Converter Scan Sequencer

This block runs a complete scan of a 10-bit converter each time a trigger arrives. The channels it scans are the enabled channels less the reserved ones, both sampled at the trigger. It powers the converter up and lets it settle for a fixed number of cycles. It then converts the remaining channels one at a time, lowest index first. After each start pulse it polls for end-of-conversion, then polls the channel the converter reports until that channel matches the request. Both polls run at a programmable interval and stop after a fixed budget of polls.

Results go into a packed frame register, one 16-bit slot per converted channel, with no gaps between slots. If a poll budget runs out, the scan ends at once. In that case the failing slot holds a marker value and the frame is flagged as an error. Power is removed at the end of every scan. A one-cycle done pulse and a pass/fail bit announce each frame. Triggers that arrive while a scan is busy are dropped and counted.

Top module: `adc_scan_seq`

## Requirements
- R1: At an accepted trigger the channels scanned are `chan_en_i & ~chan_rsvd_i`, and `frame_cnt_o` ends equal to the number of slots written.
- R2: Channels are started in strictly ascending index order. The k-th converted channel's result sits in `frame_o[16k+15:16k]`, zero-extended from 10 bits. Slots not written in a scan read 0.
- R3: `cv_pwr_o` is high for exactly 8 cycles before the first `cv_start_o`. Each `cv_start_o` is a one-cycle pulse, with `cv_chan_o` giving the requested channel.
- R4: End-of-conversion is sampled in the first cycle after the start pulse and then every `poll_gap_i`+1 cycles. If the 20th sample is still low, the scan ends with an error. With the first converted channel failing, `done_o` goes high 11+19*(`poll_gap_i`+1) cycles after the trigger cycle.
- R5: Once end-of-conversion is seen, `cv_smp_chan_i` is compared against the requested channel under the same interval and 20-poll budget. A match stores `cv_data_i`; running out of polls ends the scan with an error.
- R6: On an error the scan stops. The failing slot holds 0xFFFF and is counted in `frame_cnt_o`, no later channel is started, and `ok_o` is 0.
- R7: `cv_pwr_o` falls at the same clock edge that raises `done_o`, for passing and failing scans alike.
- R8: `done_o` is a single-cycle pulse. `ok_o` is valid with it and holds until the next frame ends. After reset all outputs are 0.
- R9: A trigger seen while a scan is busy is ignored, including in the final busy cycle. Each such trigger adds one to `overrun_o`, which saturates at 255. A trigger in the cycle where `done_o` is high starts a new scan.
- R10: An empty channel set gives `done_o` with `ok_o`=1 and `frame_cnt_o`=0 one cycle after the trigger, and `cv_pwr_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Scan request, sampled each cycle |
| chan_en_i | input | 8 | Channel enable mask |
| chan_rsvd_i | input | 8 | Reserved channels, removed from the mask |
| poll_gap_i | input | 8 | Idle cycles between polls |
| cv_pwr_o | output | 1 | Converter power request |
| cv_start_o | output | 1 | Conversion start pulse |
| cv_chan_o | output | 3 | Requested channel |
| cv_eoc_i | input | 1 | Converter end-of-conversion |
| cv_smp_chan_i | input | 3 | Channel the converter reports as sampled |
| cv_data_i | input | 10 | Conversion result |
| frame_o | output | 128 | Packed result slots, slot 0 in the low bits |
| frame_cnt_o | output | 4 | Number of slots written in the last scan |
| done_o | output | 1 | Frame end pulse |
| ok_o | output | 1 | 1 = frame valid, 0 = frame error |
| overrun_o | output | 8 | Dropped trigger count |

## Verification
Two events can fall in the same cycle: a new trigger arriving, and the end of a frame. The end of a frame is either the last poll expiring or `done_o` being shown. The bench forces a timeout on the first channel, with a known poll gap, so the cycle of the final failing poll can be computed exactly. It raises the trigger in that cycle and expects an error frame, an overrun increment and no new power-up. It then raises the trigger in the cycle where `done_o` is high and expects power to rise on the next cycle, with the overrun count unchanged and a correct frame at the end.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAKE,
    S_START,
    S_EOC,
    S_CHK
  } scan_state_t;
endpackage

// File: rtl/scan_next_pick.sv
module scan_next_pick #(
  parameter int CH = 8,
  parameter int IW = $clog2(CH)
) (
  input  logic [CH-1:0] mask_i,
  input  logic [IW-1:0] from_i,
  input  logic          from_start_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // Lowest enabled channel above from_i (or the lowest overall).
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = CH - 1; i >= 0; i--) begin
      if (mask_i[i] && (from_start_i || i > int'(from_i))) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/scan_poll_timer.sv
module scan_poll_timer #(
  parameter int GAP_W  = 8,
  parameter int BUDGET = 20,
  parameter int TW     = $clog2(BUDGET + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic             cond_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             hit_o,
  output logic             expire_o
);
  logic [GAP_W-1:0] gap_q;
  logic [TW-1:0]    tries_q;
  logic             poll_now;

  assign poll_now = active_i && (gap_q == '0);
  assign hit_o    = poll_now && cond_i;
  assign expire_o = poll_now && !cond_i && (tries_q == TW'(BUDGET - 1));

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      gap_q   <= '0;
      tries_q <= '0;
    end else if (active_i) begin
      if (gap_q == '0) begin
        tries_q <= tries_q + 1'b1;
        gap_q   <= gap_i;
      end else begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end

  // R4 / R5: a wait never runs past its poll budget
  p_budget_r4: assert property (@(posedge clk) disable iff (rst)
    (active_i && !restart_i) |-> (tries_q < TW'(BUDGET)));
endmodule

// File: rtl/scan_result_buf.sv
module scan_result_buf #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 16,
  parameter int IW     = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear_i,
  input  logic                    we_i,
  input  logic [IW-1:0]           idx_i,
  input  logic [SLOT_W-1:0]       data_i,
  output logic [SLOTS*SLOT_W-1:0] frame_o
);
  logic [SLOT_W-1:0] slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear_i)
        slot_q[s] <= '0;
      else if (we_i && idx_i == IW'(s))
        slot_q[s] <= data_i;
    end
    assign frame_o[s*SLOT_W +: SLOT_W] = slot_q[s];
  end

  // R2: a clear and a write never coincide
  p_clear_we_r2: assert property (@(posedge clk) disable iff (rst)
    clear_i |-> !we_i);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CH        = 8,
  parameter int DATA_W    = 10,
  parameter int SLOT_W    = 16,
  parameter int GAP_W     = 8,
  parameter int WAKE      = 8,
  parameter int BUDGET    = 20,
  parameter int OVR_W     = 8,
  parameter int IW        = $clog2(CH),
  parameter int CW        = $clog2(CH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 trig_i,
  input  logic [CH-1:0]        chan_en_i,
  input  logic [CH-1:0]        chan_rsvd_i,
  input  logic [GAP_W-1:0]     poll_gap_i,
  output logic                 cv_pwr_o,
  output logic                 cv_start_o,
  output logic [IW-1:0]        cv_chan_o,
  input  logic                 cv_eoc_i,
  input  logic [IW-1:0]        cv_smp_chan_i,
  input  logic [DATA_W-1:0]    cv_data_i,
  output logic [CH*SLOT_W-1:0] frame_o,
  output logic [CW-1:0]        frame_cnt_o,
  output logic                 done_o,
  output logic                 ok_o,
  output logic [OVR_W-1:0]     overrun_o
);
  localparam int WK_W = $clog2(WAKE + 1);
  localparam logic [SLOT_W-1:0] FAIL_MARK = '1;

  scan_state_t       state;
  logic [CH-1:0]     mask_q;
  logic [IW-1:0]     cur_q;
  logic [CW-1:0]     cnt_q;
  logic [WK_W-1:0]   wake_q;
  logic              pwr_q, done_q, ok_q;
  logic [OVR_W-1:0]  ovr_q;
  logic [7:0]        pwr_age_q;

  logic [CH-1:0]     eff_mask;
  logic              pick_found;
  logic [IW-1:0]     pick_idx;
  logic              wait_active, poll_restart, poll_cond, poll_hit, poll_expire;
  logic              buf_clear, buf_we;
  logic [SLOT_W-1:0] buf_data;

  assign eff_mask = chan_en_i & ~chan_rsvd_i;

  scan_next_pick #(.CH(CH), .IW(IW)) u_pick (
    .mask_i       (mask_q),
    .from_i       (cur_q),
    .from_start_i (state == S_WAKE),
    .found_o      (pick_found),
    .idx_o        (pick_idx)
  );

  assign wait_active  = (state == S_EOC) || (state == S_CHK);
  assign poll_cond    = (state == S_EOC) ? cv_eoc_i : (cv_smp_chan_i == cur_q);
  assign poll_restart = (state == S_START) || ((state == S_EOC) && poll_hit);

  scan_poll_timer #(.GAP_W(GAP_W), .BUDGET(BUDGET)) u_poll (
    .clk       (clk),
    .rst       (rst),
    .active_i  (wait_active),
    .restart_i (poll_restart),
    .cond_i    (poll_cond),
    .gap_i     (poll_gap_i),
    .hit_o     (poll_hit),
    .expire_o  (poll_expire)
  );

  assign buf_clear = (state == S_IDLE) && trig_i;
  assign buf_we    = ((state == S_CHK) && poll_hit) || (wait_active && poll_expire);
  assign buf_data  = poll_hit ? {{(SLOT_W-DATA_W){1'b0}}, cv_data_i} : FAIL_MARK;

  scan_result_buf #(.SLOTS(CH), .SLOT_W(SLOT_W), .IW(IW)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clear_i (buf_clear),
    .we_i    (buf_we),
    .idx_i   (cnt_q[IW-1:0]),
    .data_i  (buf_data),
    .frame_o (frame_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      mask_q <= '0;
      cur_q  <= '0;
      cnt_q  <= '0;
      wake_q <= '0;
      pwr_q  <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      ovr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (trig_i && state != S_IDLE && ovr_q != '1)
        ovr_q <= ovr_q + 1'b1;
      case (state)
        S_IDLE: if (trig_i) begin
          cnt_q <= '0;
          if (eff_mask == '0) begin
            done_q <= 1'b1;
            ok_q   <= 1'b1;
          end else begin
            mask_q <= eff_mask;
            pwr_q  <= 1'b1;
            wake_q <= '0;
            state  <= S_WAKE;
          end
        end
        S_WAKE: begin
          if (wake_q == WK_W'(WAKE - 1)) begin
            cur_q <= pick_idx;
            state <= S_START;
          end else begin
            wake_q <= wake_q + 1'b1;
          end
        end
        S_START: state <= S_EOC;
        S_EOC: begin
          if (poll_hit) begin
            state <= S_CHK;
          end else if (poll_expire) begin
            cnt_q  <= cnt_q + 1'b1;
            pwr_q  <= 1'b0;
            done_q <= 1'b1;
            ok_q   <= 1'b0;
            state  <= S_IDLE;
          end
        end
        S_CHK: begin
          if (poll_hit) begin
            cnt_q <= cnt_q + 1'b1;
            if (pick_found) begin
              cur_q <= pick_idx;
              state <= S_START;
            end else begin
              pwr_q  <= 1'b0;
              done_q <= 1'b1;
              ok_q   <= 1'b1;
              state  <= S_IDLE;
            end
          end else if (poll_expire) begin
            cnt_q  <= cnt_q + 1'b1;
            pwr_q  <= 1'b0;
            done_q <= 1'b1;
            ok_q   <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Cycles since power came up, used only by the checks below.
  always_ff @(posedge clk) begin
    if (rst || !pwr_q)
      pwr_age_q <= '0;
    else if (pwr_age_q != '1)
      pwr_age_q <= pwr_age_q + 1'b1;
  end

  assign cv_pwr_o    = pwr_q;
  assign cv_start_o  = (state == S_START);
  assign cv_chan_o   = cur_q;
  assign frame_cnt_o = cnt_q;
  assign done_o      = done_q;
  assign ok_o        = ok_q;
  assign overrun_o   = ovr_q;

  p_wake_r3: assert property (@(posedge clk) disable iff (rst)
    cv_start_o |-> (cv_pwr_o && pwr_age_q >= 8'(WAKE)));
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cv_start_o |=> !cv_start_o);
  p_pwr_down_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !cv_pwr_o);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_fail_mark_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && !ok_o) |-> (cnt_q != '0 &&
      frame_o[SLOT_W*(int'(cnt_q)-1) +: SLOT_W] == FAIL_MARK));
  p_empty_ok_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && cnt_q == '0) |-> ok_o);
  p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
    (trig_i && state != S_IDLE && ovr_q != '1) |=> (ovr_q == $past(ovr_q) + 1'b1));
  p_slot_range_r2: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (cnt_q < CW'(CH)));
endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         trig = 1'b0;
  logic [7:0]   chan_en = '0, chan_rsvd = '0, poll_gap = '0;
  logic         cv_pwr, cv_start, cv_eoc, done, ok;
  logic [2:0]   cv_chan, cv_smp;
  logic [9:0]   cv_data;
  logic [127:0] frame;
  logic [3:0]   fcnt;
  logic [7:0]   ovr;

  always #5 clk = ~clk;

  adc_scan_seq u0 (
    .clk(clk), .rst(rst), .trig_i(trig), .chan_en_i(chan_en), .chan_rsvd_i(chan_rsvd),
    .poll_gap_i(poll_gap), .cv_pwr_o(cv_pwr), .cv_start_o(cv_start), .cv_chan_o(cv_chan),
    .cv_eoc_i(cv_eoc), .cv_smp_chan_i(cv_smp), .cv_data_i(cv_data), .frame_o(frame),
    .frame_cnt_o(fcnt), .done_o(done), .ok_o(ok), .overrun_o(ovr)
  );

  int n_run = 0, n_fail = 0, cyc = 0, seed_v = 0;

  // Converter model: fk 0 = healthy, 1 = channel fch never finishes, 2 = channel fch reports a wrong index
  int fk = 0, fch = 0, lat_cfg = 1, mism_cfg = 0;
  int lat_c = 0, mism_c = 0;
  logic [2:0] req = '0;
  logic       eoc_q = 1'b0;

  function automatic logic [9:0] dat(input logic [2:0] ch, input int s);
    return 10'((int'(ch) * 37 + s * 5 + 3) % 1024);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      eoc_q <= 1'b0; lat_c <= 0; mism_c <= 0; req <= '0;
    end else if (cv_start) begin
      req <= cv_chan; eoc_q <= 1'b0; lat_c <= lat_cfg; mism_c <= mism_cfg;
    end else begin
      if (lat_c > 0) lat_c <= lat_c - 1;
      if (lat_c == 1 && !(fk == 1 && int'(req) == fch)) eoc_q <= 1'b1;
      if (mism_c > 0) mism_c <= mism_c - 1;
    end
  end
  assign cv_eoc  = eoc_q;
  assign cv_smp  = (mism_c > 0 || (fk == 2 && int'(req) == fch)) ? req + 3'd1 : req;
  assign cv_data = dat(req, seed_v);

  // Monitor of power and start activity, sampled at the rising edge
  logic mon_clr = 1'b0;
  int   pre_cnt = 0, last_ch = -1;
  bit   started = 0, pwr_seen = 0, order_bad = 0;
  always @(posedge clk) begin
    if (mon_clr) begin
      pre_cnt = 0; started = 0; pwr_seen = 0; order_bad = 0; last_ch = -1;
    end else begin
      if (cv_pwr) pwr_seen = 1;
      if (cv_pwr && !started && !cv_start) pre_cnt++;
      if (cv_start) begin
        started = 1;
        if (int'(cv_chan) <= last_ch) order_bad = 1;
        last_ch = int'(cv_chan);
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected<190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit good, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic expect_frame(input logic [7:0] eff, input int fk_, input int fch_, input int s,
                              output logic [127:0] f, output int c, output bit good);
    f = '0; c = 0; good = 1;
    for (int ch = 0; ch < 8; ch++) begin
      if (eff[ch] && good) begin
        if (fk_ != 0 && ch == fch_) begin
          f[c*16 +: 16] = 16'hFFFF; good = 0;
        end else begin
          f[c*16 +: 16] = {6'd0, dat(3'(ch), s)};
        end
        c++;
      end
    end
  endtask

  task automatic launch(input logic [7:0] en, input logic [7:0] res, input int gap,
                        input int lat, input int fkind, input int fchan, input int mism);
    chan_en = en; chan_rsvd = res; poll_gap = 8'(gap); lat_cfg = lat;
    fk = fkind; fch = fchan; mism_cfg = mism; seed_v++;
    trig = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    trig = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic wait_done(inout int n);
    while (!done && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic do_scan(input logic [7:0] en, input logic [7:0] res, input int gap, input int lat,
                         input int fkind, input int fchan, input int mism, output int n);
    @(negedge clk);
    launch(en, res, gap, lat, fkind, fchan, mism);
    n = 1;
    wait_done(n);
  endtask

  task automatic verify(input logic [7:0] en, input logic [7:0] res, input int fkind, input int fchan);
    logic [127:0] ef; int ec; bit eok;
    expect_frame(en & ~res, fkind, fchan, seed_v, ef, ec, eok);
    chk(done === 1'b1, "R8 done pulse seen", 128'(done), 128'd1);
    chk(frame === ef, "R2 packed frame", frame, ef);
    chk(fcnt === 4'(ec), "R1 slot count", 128'(fcnt), 128'(ec));
    chk(ok === eok, "R6 frame ok flag", 128'(ok), 128'(eok));
    chk(cv_pwr === 1'b0, "R7 power down at done", 128'(cv_pwr), 128'd0);
    if (ec > 0) begin
      chk(pre_cnt == 8, "R3 settle cycles", 128'(pre_cnt), 128'd8);
      chk(!order_bad, "R2 ascending starts", 128'(order_bad), 128'd0);
    end else begin
      chk(!pwr_seen, "R10 no power for empty set", 128'(pwr_seen), 128'd0);
    end
    @(negedge clk);
    chk(done === 1'b0, "R8 single-cycle done", 128'(done), 128'd0);
    chk(ok === eok, "R8 ok held", 128'(ok), 128'(eok));
  endtask

  initial begin
    int n;
    logic [7:0] ovr0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cv_pwr === 0 && done === 0 && ok === 0, "R8 reset controls", {cv_pwr, done, ok}, 0);
    chk(frame === '0 && fcnt === 0 && ovr === 0, "R8 reset data", frame, 0);

    // R1 R2 R3 R10: every enable mask, nothing reserved
    for (int m = 0; m < 256; m++) begin
      do_scan(8'(m), 8'h00, m % 4, 1 + m % 5, 0, 0, 0, n);
      if (m == 0) chk(n == 1, "R10 immediate done", 128'(n), 128'd1);
      verify(8'(m), 8'h00, 0, 0);
    end

    // R1: every reserved mask against a full enable and a sparse enable
    for (int r = 0; r < 256; r++) begin
      do_scan(8'hFF, 8'(r), r % 3, 2, 0, 0, 0, n);
      verify(8'hFF, 8'(r), 0, 0);
    end
    for (int r = 0; r < 256; r += 7) begin
      do_scan(8'h6D, 8'(r), 0, 1, 0, 0, 0, n);
      verify(8'h6D, 8'(r), 0, 0);
    end

    // R5: channel report settles late but within budget
    do_scan(8'h5A, 8'h00, 1, 2, 0, 0, 10, n);
    verify(8'h5A, 8'h00, 0, 0);
    do_scan(8'hFF, 8'h00, 0, 1, 0, 0, 15, n);
    verify(8'hFF, 8'h00, 0, 0);

    // R4 R6: end-of-conversion never arrives on one channel
    for (int f = 0; f < 8; f++) begin
      do_scan(8'hFF, 8'h00, 2, 2, 1, f, 0, n);
      if (f == 0) chk(n == 11 + 19 * 3, "R4 poll budget timing", 128'(n), 128'(11 + 19 * 3));
      verify(8'hFF, 8'h00, 1, f);
    end
    do_scan(8'h81, 8'h00, 0, 1, 1, 0, 0, n);
    chk(n == 11 + 19, "R4 poll budget gap 0", 128'(n), 128'(30));
    verify(8'h81, 8'h00, 1, 0);

    // R5 R6: sampled channel never matches
    for (int f = 0; f < 8; f++) begin
      do_scan(8'hB7, 8'h00, 1, 3, 2, f, 0, n);
      verify(8'hB7, 8'h00, 2, f);
    end

    // R9: trigger in the middle of a scan
    ovr0 = ovr;
    @(negedge clk);
    launch(8'hFF, 8'h00, 1, 2, 0, 0, 0);
    repeat (20) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    n = 0;
    wait_done(n);
    chk(ovr === ovr0 + 8'd1, "R9 overrun counted", 128'(ovr), 128'(ovr0 + 8'd1));
    verify(8'hFF, 8'h00, 0, 0);

    // R9: trigger in the cycle the last poll expires, then in the done cycle
    ovr0 = ovr;
    @(negedge clk);
    launch(8'h03, 8'h00, 2, 2, 1, 0, 0);
    n = 1;
    while (n < 10 + 19 * 3) begin @(negedge clk); n++; end
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(done === 1'b1 && ok === 1'b0, "R6 error frame on final poll", {done, ok}, 2'b10);
    chk(ovr === ovr0 + 8'd1, "R9 final busy cycle counted", 128'(ovr), 128'(ovr0 + 8'd1));
    repeat (3) begin
      @(negedge clk);
      chk(cv_pwr === 1'b0 && done === 1'b0, "R9 late trigger ignored", {cv_pwr, done}, 0);
    end
    ovr0 = ovr;
    launch(8'h03, 8'h00, 2, 2, 1, 0, 0);
    n = 1;
    wait_done(n);
    launch(8'hC3, 8'h00, 1, 2, 0, 0, 0);
    chk(cv_pwr === 1'b1, "R9 trigger in done cycle accepted", 128'(cv_pwr), 128'd1);
    chk(ovr === ovr0, "R9 no overrun in done cycle", 128'(ovr), 128'(ovr0));
    n = 0;
    wait_done(n);
    verify(8'hC3, 8'h00, 0, 0);

    summary();
    $finish;
  end
endmodule